// File: doc/BRIEF.md
# Register Pair File with Rename-Based Exchange

This block holds the general register pairs of a small 8-bit processor core, arranged as 16-bit pairs and named by a 3-bit pair code. Reads and writes are addressed by the architectural pair name. Each name is resolved to a physical storage slot through a small set of mapping bits that the block keeps inside itself.

Three exchange commands each complete in a single clock cycle. One swaps the two data pairs (DE and HL). One swaps the accumulator/flag pair with its shadow. One swaps the three general pairs (BC, DE, HL) with their shadow bank. None of them moves any data. Each one only toggles a mapping bit, so a value written under one name reads back under the other name from the same physical slot. The two index pairs sit outside the renaming scheme. An index-qualified form of the data-pair exchange is therefore ignored.

Reads are registered: the data for a name presented at a clock edge appears on the output after that edge. Writes take per-byte enables. Instruction decode, the ALU and memory access live elsewhere.

Top module: `regpair_rename`

## Requirements
- R1: While `rst` is high, and in the cycle after it was sampled high, `rd_data` is zero. Reset clears all mapping bits, so every name maps to its default slot.
- R2: The pair named by `rd_name` at a rising edge appears on `rd_data` after that edge. Bits 15:8 hold the first register of the pair (A, B, D, H) and bits 7:0 hold the second.
- R3: A write stores `wr_data[15:8]` when `wr_be[1]` is high and `wr_data[7:0]` when `wr_be[0]` is high. A byte whose enable is low keeps its old value.
- R4: A cycle with `ex_de_hl` high and `ex_idx` low makes later reads of DE return what HL held, and the reverse. A value written to DE before the exchange is read back as HL.
- R5: A cycle with `ex_af` high swaps AF with its shadow copy for all later accesses.
- R6: A cycle with `ex_bank` high swaps BC, DE and HL with their shadow set. AF, IX and IY are not affected.
- R7: The DE/HL swap state is kept per bank. An exchange of DE and HL made in one bank does not change what DE and HL show in the other bank.
- R8: `ex_de_hl` together with `ex_idx` changes nothing. IX and IY always read from their own fixed slots.
- R9: A write in the same cycle as an exchange resolves through the mapping as it was before the exchange. A read issued in that cycle also uses the old mapping, and returns the content from before that cycle's write.
- R10: The name codes are 0=BC, 1=DE, 2=HL, 3=AF, 4=IX, 5=IY. Codes 6 and 7 read as zero, and writes to them are discarded.
- R11: When `ex_de_hl` and `ex_bank` occur in the same cycle, the DE/HL swap applies to the bank that was active before the bank exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_name | input | 3 | Architectural pair name to read |
| rd_data | output | 16 | Registered read data |
| wr_en | input | 1 | Write strobe |
| wr_name | input | 3 | Architectural pair name to write |
| wr_be | input | 2 | Byte enables, bit 1 high byte, bit 0 low byte |
| wr_data | input | 16 | Write data |
| ex_de_hl | input | 1 | Exchange DE and HL in the active bank |
| ex_af | input | 1 | Exchange AF with its shadow |
| ex_bank | input | 1 | Exchange BC/DE/HL with the shadow bank |
| ex_idx | input | 1 | Index qualifier; suppresses `ex_de_hl` |

## Verification
The collision of interest is an exchange landing in the same cycle as a write and a read. The write must use the old mapping and the read must see both the old mapping and the old content. The bench provokes this with directed cycles that write DE or AF while issuing the matching exchange and reading the same name. It also runs a long stretch of arbitrary mixes of all inputs, including stacked exchanges. Each read is judged against a reference model that physically swaps contents in the order write, then data-pair swap, then bank swap.

// File: rtl/regpair_pkg.sv
package regpair_pkg;

  localparam int NAME_W      = 3;
  localparam int GP_PER_BANK = 3;
  localparam int NUM_PHYS    = 2 * GP_PER_BANK + 4;
  localparam int PHYS_W      = $clog2(NUM_PHYS);

  // architectural pair codes
  localparam logic [NAME_W-1:0] RN_BC = 3'd0;
  localparam logic [NAME_W-1:0] RN_DE = 3'd1;
  localparam logic [NAME_W-1:0] RN_HL = 3'd2;
  localparam logic [NAME_W-1:0] RN_AF = 3'd3;
  localparam logic [NAME_W-1:0] RN_IX = 3'd4;
  localparam logic [NAME_W-1:0] RN_IY = 3'd5;

  // physical slots: two general banks, two AF copies, two fixed index pairs
  localparam int PH_AF0 = 2 * GP_PER_BANK;
  localparam int PH_IX  = PH_AF0 + 2;
  localparam int PH_IY  = PH_AF0 + 3;

  typedef struct packed {
    logic [1:0] dehl;  // DE/HL swap bit, one per bank
    logic       af;    // AF shadow select
    logic       bank;  // general bank select
  } map_t;

  typedef struct packed {
    logic              vld;
    logic [PHYS_W-1:0] idx;
  } loc_t;

  function automatic loc_t resolve(input logic [NAME_W-1:0] name, input map_t m);
    loc_t              r;
    logic [PHYS_W-1:0] base;
    logic              sw;
    base  = m.bank ? PHYS_W'(GP_PER_BANK) : '0;
    sw    = m.dehl[m.bank];
    r.vld = 1'b1;
    r.idx = '0;
    case (name)
      RN_BC:   r.idx = base;
      RN_DE:   r.idx = base + (sw ? PHYS_W'(2) : PHYS_W'(1));
      RN_HL:   r.idx = base + (sw ? PHYS_W'(1) : PHYS_W'(2));
      RN_AF:   r.idx = PHYS_W'(PH_AF0) + PHYS_W'(m.af);
      RN_IX:   r.idx = PHYS_W'(PH_IX);
      RN_IY:   r.idx = PHYS_W'(PH_IY);
      default: r.vld = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/regpair_map.sv
module regpair_map
  import regpair_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ex_de_hl,
  input  logic              ex_af,
  input  logic              ex_bank,
  input  logic              ex_idx,
  input  logic [NAME_W-1:0] rd_name,
  input  logic [NAME_W-1:0] wr_name,
  output map_t              map_q,
  output loc_t              rd_loc,
  output loc_t              wr_loc
);

  map_t map_d;

  // both ports resolve through the mapping held at this edge
  assign rd_loc = resolve(rd_name, map_q);
  assign wr_loc = resolve(wr_name, map_q);

  always_comb begin
    map_d = map_q;
    if (ex_de_hl && !ex_idx) map_d.dehl[map_q.bank] = ~map_q.dehl[map_q.bank];
    if (ex_af)               map_d.af   = ~map_q.af;
    if (ex_bank)             map_d.bank = ~map_q.bank;
  end

  always_ff @(posedge clk) begin
    if (rst) map_q <= '0;
    else     map_q <= map_d;
  end

endmodule

// File: rtl/regpair_store.sv
module regpair_store #(
  parameter int DATA_W   = 8,
  parameter int LANES    = 2,
  parameter int NUM_PHYS = 10,
  parameter int PHYS_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_vld,
  input  logic [PHYS_W-1:0]       rd_idx,
  input  logic                    wr_en,
  input  logic                    wr_vld,
  input  logic [PHYS_W-1:0]       wr_idx,
  input  logic [LANES-1:0]        wr_be,
  input  logic [DATA_W*LANES-1:0] wr_data,
  output logic [DATA_W*LANES-1:0] rd_data
);

  logic vld_q;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= rd_vld;
  end

  // one narrow memory per byte lane, read-first, registered read
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] mem [NUM_PHYS];
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_vld && wr_be[g]) mem[wr_idx] <= wr_data[g*DATA_W +: DATA_W];
      q <= mem[rd_idx];
    end

    assign rd_data[g*DATA_W +: DATA_W] = vld_q ? q : '0;
  end

endmodule

// File: rtl/regpair_rename.sv
module regpair_rename
  import regpair_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          rd_name,
  output logic [2*DATA_W-1:0] rd_data,
  input  logic                wr_en,
  input  logic [2:0]          wr_name,
  input  logic [1:0]          wr_be,
  input  logic [2*DATA_W-1:0] wr_data,
  input  logic                ex_de_hl,
  input  logic                ex_af,
  input  logic                ex_bank,
  input  logic                ex_idx
);

  localparam int LANES = 2;

  map_t map_q;
  loc_t rd_loc;
  loc_t wr_loc;

  regpair_map u_map (
    .clk      (clk),
    .rst      (rst),
    .ex_de_hl (ex_de_hl),
    .ex_af    (ex_af),
    .ex_bank  (ex_bank),
    .ex_idx   (ex_idx),
    .rd_name  (rd_name),
    .wr_name  (wr_name),
    .map_q    (map_q),
    .rd_loc   (rd_loc),
    .wr_loc   (wr_loc)
  );

  regpair_store #(
    .DATA_W   (DATA_W),
    .LANES    (LANES),
    .NUM_PHYS (NUM_PHYS),
    .PHYS_W   (PHYS_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_vld  (rd_loc.vld),
    .rd_idx  (rd_loc.idx),
    .wr_en   (wr_en),
    .wr_vld  (wr_loc.vld),
    .wr_idx  (wr_loc.idx),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/regpair_rename_chk.sv
module regpair_rename_chk #(
  parameter int PAIR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        rd_name,
  input logic [PAIR_W-1:0] rd_data,
  input logic              ex_de_hl,
  input logic              ex_af,
  input logic              ex_bank,
  input logic              ex_idx,
  input logic              map_bank,
  input logic              map_af,
  input logic [1:0]        map_dehl
);

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> (rd_data == '0));

  a_r4_dehl_flip: assert property (@(posedge clk) disable iff (rst)
    (ex_de_hl && !ex_idx) |=> ($countones(map_dehl ^ $past(map_dehl)) == 1));

  a_r5_af_flip: assert property (@(posedge clk) disable iff (rst)
    ex_af |=> (map_af != $past(map_af)));

  a_r6_bank_flip: assert property (@(posedge clk) disable iff (rst)
    ex_bank |=> (map_bank != $past(map_bank)));

  a_r8_idx_hold: assert property (@(posedge clk) disable iff (rst)
    (ex_de_hl && ex_idx) |=> $stable(map_dehl));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!ex_de_hl && !ex_af && !ex_bank) |=> $stable({map_dehl, map_af, map_bank}));

  a_r10_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_name >= 3'd6) |=> (rd_data == '0));

endmodule

bind regpair_rename regpair_rename_chk #(.PAIR_W(2*DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_name  (rd_name),
  .rd_data  (rd_data),
  .ex_de_hl (ex_de_hl),
  .ex_af    (ex_af),
  .ex_bank  (ex_bank),
  .ex_idx   (ex_idx),
  .map_bank (map_q.bank),
  .map_af   (map_q.af),
  .map_dehl (map_q.dehl)
);

// File: tb/regpair_rename_tb.sv
`timescale 1ns/1ps
module regpair_rename_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  rd_name = '0;
  logic [15:0] rd_data;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_name = '0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic        ex_de_hl = 1'b0;
  logic        ex_af = 1'b0;
  logic        ex_bank = 1'b0;
  logic        ex_idx = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  regpair_rename u_dut (
    .clk(clk), .rst(rst), .rd_name(rd_name), .rd_data(rd_data),
    .wr_en(wr_en), .wr_name(wr_name), .wr_be(wr_be), .wr_data(wr_data),
    .ex_de_hl(ex_de_hl), .ex_af(ex_af), .ex_bank(ex_bank), .ex_idx(ex_idx)
  );

  // reference model that really moves contents
  logic [15:0] m_gp [3];
  logic [15:0] m_gs [3];
  logic [15:0] m_af, m_afs, m_ix, m_iy;

  logic [15:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [15:0] model_read(input logic [2:0] n);
    case (n)
      3'd0, 3'd1, 3'd2: return m_gp[n];
      3'd3:             return m_af;
      3'd4:             return m_ix;
      3'd5:             return m_iy;
      default:          return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [1:0] be,
                                        input logic [15:0] d);
    return {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
  endfunction

  task automatic model_write(input logic [2:0] n, input logic [1:0] be, input logic [15:0] d);
    case (n)
      3'd0, 3'd1, 3'd2: m_gp[n] = merge(m_gp[n], be, d);
      3'd3:             m_af    = merge(m_af, be, d);
      3'd4:             m_ix    = merge(m_ix, be, d);
      3'd5:             m_iy    = merge(m_iy, be, d);
      default:          ;
    endcase
  endtask

  // driver: one cycle of stimulus, one expected read pushed to the scoreboard
  task automatic cyc(input logic [2:0] rn, input logic we, input logic [2:0] wn,
                     input logic [1:0] be, input logic [15:0] wd,
                     input logic [3:0] ex, input string tag);
    logic [15:0] t;
    @(negedge clk);
    rd_name = rn; wr_en = we; wr_name = wn; wr_be = be; wr_data = wd;
    ex_de_hl = ex[0]; ex_af = ex[1]; ex_bank = ex[2]; ex_idx = ex[3];
    exp_q.push_back(model_read(rn));
    tag_q.push_back(tag);
    if (we) model_write(wn, be, wd);
    if (ex[0] && !ex[3]) begin t = m_gp[1]; m_gp[1] = m_gp[2]; m_gp[2] = t; end
    if (ex[1]) begin t = m_af; m_af = m_afs; m_afs = t; end
    if (ex[2]) begin
      for (int i = 0; i < 3; i++) begin t = m_gp[i]; m_gp[i] = m_gs[i]; m_gs[i] = t; end
    end
  endtask

  task automatic rd(input logic [2:0] rn, input string tag);
    cyc(rn, 1'b0, 3'd0, 2'b00, 16'h0, 4'b0000, tag);
  endtask

  task automatic wr(input logic [2:0] wn, input logic [1:0] be, input logic [15:0] d,
                    input string tag);
    cyc(3'd7, 1'b1, wn, be, d, 4'b0000, tag);
  endtask

  task automatic ex(input logic [3:0] code, input string tag);
    cyc(3'd7, 1'b0, 3'd0, 2'b00, 16'h0, code, tag);
  endtask

  // monitor: pops and compares after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string       tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      n_tests++;
      if (rd_data !== e) begin
        n_fail++;
        $display("FAIL %s: rd_data=%h expected %h", tg, rd_data, e);
      end
    end
  end

  initial begin
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin m_gp[i] = '0; m_gs[i] = '0; end
    m_af = '0; m_afs = '0; m_ix = '0; m_iy = '0;

    // R1: output held at zero during reset
    repeat (3) @(negedge clk);
    n_tests++;
    if (rd_data !== 16'h0) begin
      n_fail++;
      $display("FAIL R1 reset: rd_data=%h expected 0000", rd_data);
    end
    rst = 1'b0;

    // fill both banks and both AF copies (R2 default mapping, R10 codes)
    wr(3'd0, 2'b11, 16'h1122, "R2 fill");
    wr(3'd1, 2'b11, 16'h3344, "R2 fill");
    wr(3'd2, 2'b11, 16'h5566, "R2 fill");
    wr(3'd3, 2'b11, 16'h7788, "R2 fill");
    wr(3'd4, 2'b11, 16'h99AA, "R2 fill");
    wr(3'd5, 2'b11, 16'hBBCC, "R2 fill");
    ex(4'b0110, "R6 setup");
    wr(3'd0, 2'b11, 16'hA1A2, "R6 fill");
    wr(3'd1, 2'b11, 16'hB1B2, "R6 fill");
    wr(3'd2, 2'b11, 16'hC1C2, "R6 fill");
    wr(3'd3, 2'b11, 16'hD1D2, "R5 fill");
    ex(4'b0110, "R6 setup");
    for (int n = 0; n < 8; n++) rd(3'(n), "R2 R10 readback");

    // R3 byte enables
    wr(3'd1, 2'b10, 16'hEE00, "R3 high");
    rd(3'd1, "R3 high byte only");
    wr(3'd1, 2'b01, 16'h00FF, "R3 low");
    rd(3'd1, "R3 low byte only");
    wr(3'd1, 2'b00, 16'h1234, "R3 none");
    rd(3'd1, "R3 no enable");

    // R4 data pair exchange
    wr(3'd1, 2'b11, 16'h0022, "R4 load DE");
    ex(4'b0001, "R4 swap");
    rd(3'd2, "R4 HL shows loaded DE");
    rd(3'd1, "R4 DE shows old HL");
    ex(4'b0001, "R4 swap back");
    rd(3'd1, "R4 DE restored");

    // R5 accumulator shadow
    ex(4'b0010, "R5 swap");
    rd(3'd3, "R5 AF shadow");
    rd(3'd0, "R5 BC untouched");
    ex(4'b0010, "R5 swap back");
    rd(3'd3, "R5 AF restored");

    // R6 bank exchange
    ex(4'b0100, "R6 swap");
    for (int n = 0; n < 6; n++) rd(3'(n), "R6 bank swapped");

    // R7 per-bank DE/HL state
    ex(4'b0001, "R7 swap in shadow bank");
    rd(3'd1, "R7 shadow DE");
    ex(4'b0100, "R7 back to main");
    rd(3'd1, "R7 main DE unchanged");
    rd(3'd2, "R7 main HL unchanged");
    ex(4'b0100, "R7 to shadow");
    rd(3'd2, "R7 shadow HL kept swap");
    ex(4'b0100, "R7 to main");

    // R8 index-qualified exchange ignored
    ex(4'b1001, "R8 idx exchange");
    rd(3'd1, "R8 DE unchanged");
    rd(3'd2, "R8 HL unchanged");
    rd(3'd4, "R8 IX unchanged");
    rd(3'd5, "R8 IY unchanged");

    // R9 write and read in the exchange cycle
    cyc(3'd1, 1'b1, 3'd1, 2'b11, 16'h5A5A, 4'b0001, "R9 read old DE in swap cycle");
    rd(3'd2, "R9 write landed in old DE");
    rd(3'd1, "R9 DE after swap");
    cyc(3'd3, 1'b1, 3'd3, 2'b11, 16'hC3C3, 4'b0010, "R9 read old AF in swap cycle");
    rd(3'd3, "R9 AF shadow after swap");
    ex(4'b0010, "R9 AF back");
    rd(3'd3, "R9 write in old AF");

    // R11 stacked exchanges
    ex(4'b0101, "R11 dehl with bank");
    rd(3'd1, "R11 DE");
    rd(3'd2, "R11 HL");
    ex(4'b0100, "R11 bank back");
    rd(3'd1, "R11 DE after return");
    rd(3'd2, "R11 HL after return");

    // R10 unused codes
    wr(3'd6, 2'b11, 16'hFFFF, "R10 write ignored");
    wr(3'd7, 2'b11, 16'hFFFF, "R10 write ignored");
    for (int n = 0; n < 8; n++) rd(3'(n), "R10 unused codes");

    // R9 mixed traffic against the model
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[2:0], r[3], r[6:4], r[8:7], r[24:9], {r[28] & r[29], r[27:25]}, "R9 mixed");
    end

    @(negedge clk);
    rd_name = 3'd7; wr_en = 1'b0;
    ex_de_hl = 1'b0; ex_af = 1'b0; ex_bank = 1'b0; ex_idx = 1'b0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule